// File: doc/BRIEF.md
# Stereo Sample Elastic Shift Buffer

This block decouples a bursty producer of stereo audio samples from a DAC that takes samples at a steady pace. Each sample is one packed word with the left channel in the upper half and the right channel in the lower half, both signed two's complement. The producer may deliver zero, one or two samples between DAC requests. The buffer absorbs this jitter in a small queue whose depth is a parameter (4 by default, 5 is also a sensible choice).

The storage is a shift register, not a pointer ring. An accepted sample enters slot 0 and every stored word moves up one slot. A read takes the slot at index level minus one, which is always the oldest word, so delivery order is preserved even when two pushes arrive back to back. When the DAC asks for data, the oldest word is split into two channel outputs. The sign bit of each channel is inverted to give offset binary, and a one-cycle load strobe marks the new value. On overflow the incoming sample is discarded and a drop pulse is raised. On underflow nothing is loaded and the DAC keeps repeating its last value. After reset the queue already counts silence entries (a parameter, 1 by default), so the DAC has a word to take before real audio arrives.

Input stream rules: `in_ready` is always high and the producer is never stalled. A beat with `in_valid` high is either stored, or dropped when the queue is full and no pop happens in the same cycle. The DAC side uses a level-sensitive ready. It must drop `dac_ready` within one cycle after seeing `dac_load`, and raise it again when it wants the next word.

Top module: `stereo_elastic_buf`

## Requirements
- R1: While reset is low and after it is released, `level` equals PRIME_SLOTS (1), `dac_left` and `dac_right` are 0x8000, and `dac_load` and `drop` are low.
- R2: The first word delivered after reset is the primed silence: `dac_left` = `dac_right` = 0x8000 with `dac_load` high.
- R3: Accepted samples reach the DAC outputs in the order they were pushed, including back-to-back pushes.
- R4: For a delivered word W, `dac_left` = W[31:16] XOR 0x8000 and `dac_right` = W[15:0] XOR 0x8000.
- R5: A push with `level` below DEPTH and no pop in that cycle raises `level` by one after the edge. `level` never exceeds DEPTH.
- R6: A push with `level` equal to DEPTH and no pop in that cycle is discarded. `drop` is high for exactly the following cycle, and `level` and the stored contents are unchanged.
- R7: A pop happens at an edge only when `dac_ready` is high, `level` is nonzero and `dac_load` is low. `dac_load` is high in the next cycle with the popped word, and `level` drops by one.
- R8: With `level` at zero, no load occurs while `dac_ready` is high. `dac_left` and `dac_right` hold their last values whenever `dac_load` is low.
- R9: A push and a pop at the same edge leave `level` unchanged, even when full. The pop returns the oldest word from before the shift, and no drop occurs.
- R10: `in_ready` is high at all times.
- R11: `dac_load` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer sample valid |
| in_ready | output | 1 | Always high; overflow drops instead of stalling |
| in_sample | input | 32 | Packed sample, left in [31:16], right in [15:0], signed |
| dac_ready | input | 1 | DAC wants a new word; must fall within one cycle after `dac_load` |
| dac_load | output | 1 | One-cycle strobe: new channel values are valid |
| dac_left | output | 16 | Left channel, offset binary |
| dac_right | output | 16 | Right channel, offset binary |
| level | output | 3 | Number of stored words |
| drop | output | 1 | One-cycle pulse after a discarded push |

## Verification
A wrong read index or shift shows on the very next load strobe as a word out of push order. The scoreboard catches this on the first affected delivery, one cycle after the pop edge. A level counter that drifts shows within one cycle on `level`. It also shows as a drop when a slot is still free, or as loads that continue past the last stored word. A broken hold path shows as output values changing while `dac_load` is low during an underflow. The merged push-and-pop case is exercised at both mid and full occupancy, because a wrong ordering between read and shift there returns the second-oldest word.

// File: rtl/esb_pkg.sv
package esb_pkg;
  localparam int CH_W  = 16;
  localparam int SMP_W = 2 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] left;
    logic [CH_W-1:0] right;
  } stereo_t;

  localparam logic [CH_W-1:0] SIGN_FLIP = {1'b1, {(CH_W-1){1'b0}}};
endpackage

// File: rtl/esb_level.sv
module esb_level #(
  parameter int DEPTH = 4,
  parameter int PRIME = 1,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic [LVL_W-1:0] level,
  output logic             pop_go,
  output logic             push_go,
  output logic             drop
);
  localparam logic [LVL_W-1:0] FULL_L  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] PRIME_L = LVL_W'(PRIME);

  always_comb begin
    pop_go  = pop_req && (level != '0);
    // a pop in the same cycle frees a slot before the shift
    push_go = push_req && ((level != FULL_L) || pop_go);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= PRIME_L;
      drop  <= 1'b0;
    end else begin
      drop <= push_req && !push_go;
      unique case ({push_go, pop_go})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_L); // R5
  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> $stable(level)); // R6
endmodule

// File: rtl/esb_slots.sv
module esb_slots #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3,
  parameter int SMP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [SMP_W-1:0] din,
  input  logic [LVL_W-1:0] level,
  output logic [SMP_W-1:0] oldest
);
  logic [SMP_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        slot[0] <= '0;
        else if (shift_en) slot[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        slot[g] <= '0;
        else if (shift_en) slot[g] <= slot[g-1];
      end
    end
  end

  // oldest word sits at index level-1; read happens before this edge's shift
  always_comb begin
    oldest = slot[0];
    for (int i = 0; i < DEPTH; i++) begin
      if (level == LVL_W'(i + 1)) oldest = slot[i];
    end
  end
endmodule

// File: rtl/esb_dac_out.sv
module esb_dac_out
  import esb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  stereo_t         word,
  output logic [CH_W-1:0] dac_left,
  output logic [CH_W-1:0] dac_right,
  output logic            dac_load
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_left  <= SIGN_FLIP;
      dac_right <= SIGN_FLIP;
      dac_load  <= 1'b0;
    end else begin
      dac_load <= load_en;
      if (load_en) begin
        dac_left  <= word.left  ^ SIGN_FLIP;
        dac_right <= word.right ^ SIGN_FLIP;
      end
    end
  end

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load |-> $stable({dac_left, dac_right})); // R8
endmodule

// File: rtl/stereo_elastic_buf.sv
module stereo_elastic_buf
  import esb_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int PRIME_SLOTS = 1,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_sample,
  input  logic             dac_ready,
  output logic             dac_load,
  output logic [CH_W-1:0]  dac_left,
  output logic [CH_W-1:0]  dac_right,
  output logic [LVL_W-1:0] level,
  output logic             drop
);
  logic             pop_go;
  logic             push_go;
  logic [SMP_W-1:0] oldest;
  stereo_t          oldest_s;

  assign in_ready = 1'b1;
  assign oldest_s = stereo_t'(oldest);

  esb_level #(.DEPTH(DEPTH), .PRIME(PRIME_SLOTS), .LVL_W(LVL_W)) level_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (in_valid),
    .pop_req  (dac_ready && !dac_load),
    .level    (level),
    .pop_go   (pop_go),
    .push_go  (push_go),
    .drop     (drop)
  );

  esb_slots #(.DEPTH(DEPTH), .LVL_W(LVL_W), .SMP_W(SMP_W)) slots_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (push_go),
    .din      (in_sample),
    .level    (level),
    .oldest   (oldest)
  );

  esb_dac_out out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (pop_go),
    .word      (oldest_s),
    .dac_left  (dac_left),
    .dac_right (dac_right),
    .dac_load  (dac_load)
  );

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |=> !dac_load); // R11
  AST_EMPTY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> !dac_load); // R8
  AST_NOT_READY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ready |=> !dac_load); // R7
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dac_ready && level < LVL_W'(DEPTH)) |=> level == $past(level) + 1'b1); // R5
  AST_MERGED_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dac_ready && !dac_load && level != '0) |=> (level == $past(level)) && !drop); // R9
endmodule

// File: tb/stereo_elastic_buf_tb_top.sv
module stereo_elastic_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_sample = '0;
  logic        dac_ready;
  logic        dac_load;
  logic [15:0] dac_left, dac_right;
  logic [2:0]  level;
  logic        drop;

  logic dac_auto = 1'b0, auto_rdy = 1'b0, dac_force = 1'b0;
  assign dac_ready = auto_rdy | dac_force;

  int checks = 0, failures = 0, n_loads = 0;
  bit prev_load = 1'b0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  stereo_elastic_buf dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .dac_ready(dac_ready), .dac_load(dac_load),
    .dac_left(dac_left), .dac_right(dac_right), .level(level), .drop(drop));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] conv(input logic [31:0] w);
    return w ^ 32'h8000_8000;
  endfunction

  // DAC model: ready drops after a load, comes back when auto mode asks
  always @(negedge clk) begin
    if (dac_load) auto_rdy = 1'b0;
    else          auto_rdy = dac_auto;
  end

  // monitor: compare each load against the scoreboard (R3, R4, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_load) begin
        n_loads++;
        chk(!prev_load, "R11 back-to-back load", 32'(prev_load), 32'd0);
        if (exp_q.size() == 0) chk(1'b0, "R8 load with empty scoreboard", {dac_left, dac_right}, 32'hx);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({dac_left, dac_right} == e, "R3/R4 delivered word", {dac_left, dac_right}, e);
        end
      end
      prev_load = dac_load;
    end
  end

  task automatic push(input logic [31:0] s, input bit accept);
    @(negedge clk);
    in_valid = 1'b1; in_sample = s;
    if (accept) exp_q.push_back(conv(s));
    @(negedge clk);
    in_valid = 1'b0;
    chk(drop == !accept, accept ? "R5 no drop" : "R6 drop pulse", 32'(drop), 32'(!accept));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    int loads_before;
    repeat (3) @(negedge clk);
    chk(level == 3'd1, "R1 level in reset", 32'(level), 32'd1);
    chk({dac_left, dac_right} == 32'h8000_8000, "R1 outputs in reset", {dac_left, dac_right}, 32'h8000_8000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dac_load && !drop, "R1 strobes low", {dac_load, drop}, 32'd0);
    chk(in_ready, "R10 in_ready", 32'(in_ready), 32'd1);
    exp_q.push_back(32'h8000_8000); // R2 primed silence

    // fill to DEPTH with back-to-back pushes
    push(32'h1234_8001, 1'b1);
    chk(level == 3'd2, "R5 level 2", 32'(level), 32'd2);
    push(32'hFFFF_0000, 1'b1);
    push(32'h7FFF_8000, 1'b1);
    chk(level == 3'd4, "R5 level full", 32'(level), 32'd4);
    // overflow
    push(32'hDEAD_BEEF, 1'b0);
    chk(level == 3'd4, "R6 level kept", 32'(level), 32'd4);
    push(32'hCAFE_F00D, 1'b0);
    @(negedge clk);
    chk(!drop, "R6 drop one cycle", 32'(drop), 32'd0);

    // R7: no ready, no load
    loads_before = n_loads;
    repeat (5) @(negedge clk);
    chk(n_loads == loads_before && level == 3'd4, "R7 idle without ready", 32'(n_loads), 32'(loads_before));

    // drain
    dac_auto = 1'b1;
    repeat (20) @(negedge clk);
    chk(level == 3'd0, "R7 drained", 32'(level), 32'd0);
    chk(n_loads == 4, "R2/R3 four words delivered", 32'(n_loads), 32'd4);
    chk(exp_q.size() == 0, "R6 dropped words not delivered", 32'(exp_q.size()), 32'd0);

    // R8: underflow holds output
    held = {dac_left, dac_right};
    loads_before = n_loads;
    repeat (8) @(negedge clk);
    chk(n_loads == loads_before, "R8 no load when empty", 32'(n_loads), 32'(loads_before));
    chk({dac_left, dac_right} == held, "R8 output held", {dac_left, dac_right}, held);
    dac_auto = 1'b0;
    repeat (3) @(negedge clk);

    // R9: merged push and pop at mid occupancy
    push(32'h0001_0002, 1'b1);
    push(32'h0003_0004, 1'b1);
    @(negedge clk);
    dac_force = 1'b1; in_valid = 1'b1; in_sample = 32'h0005_0006;
    exp_q.push_back(conv(32'h0005_0006));
    @(negedge clk);
    dac_force = 1'b0; in_valid = 1'b0;
    chk(level == 3'd2, "R9 level flat", 32'(level), 32'd2);
    chk(!drop, "R9 no drop", 32'(drop), 32'd0);

    // R9 at full occupancy
    push(32'h8000_7FFF, 1'b1);
    push(32'h0A0B_0C0D, 1'b1);
    chk(level == 3'd4, "R5 refilled", 32'(level), 32'd4);
    @(negedge clk);
    dac_force = 1'b1; in_valid = 1'b1; in_sample = 32'h5555_AAAA;
    exp_q.push_back(conv(32'h5555_AAAA));
    @(negedge clk);
    dac_force = 1'b0; in_valid = 1'b0;
    chk(level == 3'd4, "R9 full level flat", 32'(level), 32'd4);
    chk(!drop, "R9 full no drop", 32'(drop), 32'd0);

    // R11: ready held high, loads every other cycle
    @(negedge clk);
    loads_before = n_loads;
    dac_force = 1'b1;
    repeat (8) @(negedge clk);
    chk(n_loads - loads_before == 4, "R11 alternate loads", 32'(n_loads - loads_before), 32'd4);
    chk(level == 3'd0, "R7 level after pops", 32'(level), 32'd0);
    repeat (4) @(negedge clk);
    dac_force = 1'b0;
    chk(exp_q.size() == 0, "R3 scoreboard empty", 32'(exp_q.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule